// File: doc/BRIEF.md
# Synchronous Exception Priority Selector

This block takes every exception condition that a single instruction can raise and reduces them to one exception-valid flag plus the cause code that belongs in the machine cause register. The decode stage and the memory protection checks set the condition flags. This block only arbitrates among them. The order is fixed and not numeric. Faults from the fetch side win over an illegal encoding. Environment calls and breakpoints come next. Data-side faults rank last, and a store fault beats a load fault. Two causes use custom codes: 48 for a fetch bus error and 49 for a fetch integrity (parity/checksum) error.

Every flag is qualified by an execute strobe. A fetch that carries a bus error or an access fault raises nothing unless the instruction is actually executed. There is no enable for individual causes and no global mask, because exceptions cannot be disabled. A parameter selects whether the result comes straight from the combinational chain or from a register one cycle later. The default is registered.

Top module: `exc_prio_sel`

## Requirements
- R1: While reset is asserted, and on the first output after reset, `exc_valid_o` is 0 and `exc_cause_o` is 0.
- R2: `exc_valid_o` is 1 exactly when `exec_i` is 1 and at least one of the eight fault flags is 1. With the default `REG_OUT=1`, the output appears one clock after the inputs are sampled.
- R3: When `exc_valid_o` is 0, `exc_cause_o` is all zeros.
- R4: A fetch access fault has the highest priority and gives cause 1.
- R5: A fetch integrity fault (cause 49) beats a fetch bus fault (cause 48). Both lose only to a fetch access fault.
- R6: An illegal instruction gives cause 2. It beats an environment call, a breakpoint and all data faults, and it loses to every fetch fault.
- R7: An environment call gives cause 8 when `priv_user_i` is 1 and cause 11 when it is 0. It beats a breakpoint.
- R8: A breakpoint gives cause 3. It beats both data faults.
- R9: A store/AMO access fault gives cause 7. It beats a load access fault, which gives cause 5 and has the lowest priority.
- R10: The top bit of `exc_cause_o`, the interrupt flag, is always 0.
- R11: When `exec_i` is 0, every fault flag is ignored. The output is valid 0 and cause 0, even if fetch faults are flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exec_i | input | 1 | The instruction is actually being executed |
| priv_user_i | input | 1 | 1 when executing in user mode, 0 when in machine mode |
| flt_fetch_acc_i | input | 1 | Fetch access fault |
| flt_fetch_chk_i | input | 1 | Fetch parity/checksum fault |
| flt_fetch_bus_i | input | 1 | Fetch bus error |
| flt_illegal_i | input | 1 | Illegal instruction |
| flt_ecall_i | input | 1 | Environment call |
| flt_ebreak_i | input | 1 | Breakpoint |
| flt_store_i | input | 1 | Store/AMO access fault |
| flt_load_i | input | 1 | Load access fault |
| exc_valid_o | output | 1 | An exception is raised |
| exc_cause_o | output | CAUSE_W | Cause code, interrupt bit clear |

## Verification
The bench drives all 256 flag patterns under each privilege mode. This catches a chain that was ordered numerically, which would let code 1 through 11 outrank 48 and 49. It also catches one that swapped the integrity and bus codes, or ranked load above store. A swapped environment-call code would show up in every pattern where only the call and lower-ranked flags are set. Patterns with `exec_i` low but fetch faults set catch a selector that reports fetch errors before execution. Patterns with no flags catch a stale cause left behind from the previous valid cycle.

// File: rtl/exc_prio_sel.sv
module exc_prio_sel #(
  parameter bit REG_OUT = 1'b1,
  parameter int CAUSE_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               exec_i,
  input  logic               priv_user_i,
  input  logic               flt_fetch_acc_i,
  input  logic               flt_fetch_chk_i,
  input  logic               flt_fetch_bus_i,
  input  logic               flt_illegal_i,
  input  logic               flt_ecall_i,
  input  logic               flt_ebreak_i,
  input  logic               flt_store_i,
  input  logic               flt_load_i,
  output logic               exc_valid_o,
  output logic [CAUSE_W-1:0] exc_cause_o
);
  localparam logic [CAUSE_W-1:0] C_FETCH_ACC = CAUSE_W'(1);
  localparam logic [CAUSE_W-1:0] C_FETCH_CHK = CAUSE_W'(49);
  localparam logic [CAUSE_W-1:0] C_FETCH_BUS = CAUSE_W'(48);
  localparam logic [CAUSE_W-1:0] C_ILLEGAL   = CAUSE_W'(2);
  localparam logic [CAUSE_W-1:0] C_ECALL_U   = CAUSE_W'(8);
  localparam logic [CAUSE_W-1:0] C_ECALL_M   = CAUSE_W'(11);
  localparam logic [CAUSE_W-1:0] C_EBREAK    = CAUSE_W'(3);
  localparam logic [CAUSE_W-1:0] C_STORE     = CAUSE_W'(7);
  localparam logic [CAUSE_W-1:0] C_LOAD      = CAUSE_W'(5);

  logic               any_c;
  logic [CAUSE_W-1:0] cause_c;

  assign any_c = exec_i & (flt_fetch_acc_i | flt_fetch_chk_i | flt_fetch_bus_i |
                           flt_illegal_i | flt_ecall_i | flt_ebreak_i |
                           flt_store_i | flt_load_i);

  always_comb begin
    cause_c = '0;
    if (exec_i) begin
      if      (flt_fetch_acc_i) cause_c = C_FETCH_ACC;
      else if (flt_fetch_chk_i) cause_c = C_FETCH_CHK;
      else if (flt_fetch_bus_i) cause_c = C_FETCH_BUS;
      else if (flt_illegal_i)   cause_c = C_ILLEGAL;
      else if (flt_ecall_i)     cause_c = priv_user_i ? C_ECALL_U : C_ECALL_M;
      else if (flt_ebreak_i)    cause_c = C_EBREAK;
      else if (flt_store_i)     cause_c = C_STORE;
      else if (flt_load_i)      cause_c = C_LOAD;
    end
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        exc_valid_o <= 1'b0;
        exc_cause_o <= '0;
      end else begin
        exc_valid_o <= any_c;
        exc_cause_o <= cause_c;
      end
    end
  end else begin : g_comb
    assign exc_valid_o = any_c;
    assign exc_cause_o = cause_c;
  end
endmodule

// File: rtl/exc_prio_sel_chk.sv
module exc_prio_sel_chk #(
  parameter bit REG_OUT = 1'b1,
  parameter int CAUSE_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               exec_i,
  input logic               priv_user_i,
  input logic               flt_fetch_acc_i,
  input logic               flt_fetch_chk_i,
  input logic               flt_fetch_bus_i,
  input logic               flt_illegal_i,
  input logic               flt_ecall_i,
  input logic               flt_ebreak_i,
  input logic               flt_store_i,
  input logic               flt_load_i,
  input logic               exc_valid_o,
  input logic [CAUSE_W-1:0] exc_cause_o
);
  logic any_in;
  logic past_ok;

  assign any_in = exec_i & (|{flt_fetch_acc_i, flt_fetch_chk_i, flt_fetch_bus_i, flt_illegal_i,
                              flt_ecall_i, flt_ebreak_i, flt_store_i, flt_load_i});

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;

  a_r10_int_bit_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_cause_o[CAUSE_W-1]);

  a_r3_zero_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_valid_o |-> (exc_cause_o == '0));

  if (REG_OUT) begin : g_seq
    a_r2_valid_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok |-> (exc_valid_o == $past(any_in)));
    a_r11_exec_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (past_ok && !$past(exec_i)) |-> !exc_valid_o);
    a_r4_fetch_acc_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (past_ok && $past(exec_i && flt_fetch_acc_i)) |-> (exc_cause_o == CAUSE_W'(1)));
    a_r9_store_over_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (past_ok && exc_cause_o == CAUSE_W'(5)) |-> !$past(flt_store_i));
    a_r7_ecall_user: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (past_ok && exc_cause_o == CAUSE_W'(8)) |-> $past(priv_user_i));
    a_r7_ecall_mach: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (past_ok && exc_cause_o == CAUSE_W'(11)) |-> !$past(priv_user_i));
  end else begin : g_cmb
    a_r2_valid_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      exc_valid_o == any_in);
    a_r11_exec_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !exec_i |-> !exc_valid_o);
    a_r4_fetch_acc_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (exec_i && flt_fetch_acc_i) |-> (exc_cause_o == CAUSE_W'(1)));
    a_r9_store_over_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (exc_cause_o == CAUSE_W'(5)) |-> !flt_store_i);
  end
endmodule

bind exc_prio_sel exc_prio_sel_chk #(.REG_OUT(REG_OUT), .CAUSE_W(CAUSE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .exec_i(exec_i), .priv_user_i(priv_user_i),
  .flt_fetch_acc_i(flt_fetch_acc_i), .flt_fetch_chk_i(flt_fetch_chk_i),
  .flt_fetch_bus_i(flt_fetch_bus_i), .flt_illegal_i(flt_illegal_i),
  .flt_ecall_i(flt_ecall_i), .flt_ebreak_i(flt_ebreak_i),
  .flt_store_i(flt_store_i), .flt_load_i(flt_load_i),
  .exc_valid_o(exc_valid_o), .exc_cause_o(exc_cause_o)
);

// File: tb/exc_prio_sel_tb.sv
module exc_prio_sel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec = 1'b0;
  logic        user = 1'b0;
  logic [7:0]  flags = '0;
  logic        valid;
  logic [31:0] cause;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  exc_prio_sel u_dut (
    .clk_i(clk), .rst_ni(rst_n), .exec_i(exec), .priv_user_i(user),
    .flt_fetch_acc_i(flags[0]), .flt_fetch_chk_i(flags[1]), .flt_fetch_bus_i(flags[2]),
    .flt_illegal_i(flags[3]), .flt_ecall_i(flags[4]), .flt_ebreak_i(flags[5]),
    .flt_store_i(flags[6]), .flt_load_i(flags[7]),
    .exc_valid_o(valid), .exc_cause_o(cause)
  );

  typedef struct { bit v; int c; string req; } exp_t;
  exp_t q[$];

  // flags index in priority rank order, high to low
  function automatic exp_t model(bit ex, bit u, logic [7:0] f);
    int codes[8];
    string reqs[8];
    exp_t e;
    codes = '{1, 49, 48, 2, (u ? 8 : 11), 3, 7, 5};
    reqs  = '{"R4", "R5", "R5", "R6", "R7", "R8", "R9", "R9"};
    e.v = 0; e.c = 0; e.req = ex ? "R3" : "R11";
    if (ex) begin
      for (int i = 0; i < 8; i++) begin
        if (f[i]) begin e.v = 1; e.c = codes[i]; e.req = reqs[i]; break; end
      end
    end
    return e;
  endfunction

  task automatic check(bit ev, int ec, string req);
    n_run++;
    if (valid !== ev || cause !== 32'(ec) || cause[31] !== 1'b0) begin
      n_fail++;
      $display("FAIL %s (R2/R10): valid=%0b cause=%0d expected valid=%0b cause=%0d",
               req, valid, cause, ev, ec);
    end
  endtask

  task automatic step(bit ex, bit u, logic [7:0] f);
    exp_t e;
    @(negedge clk);
    if (q.size() > 0) begin e = q.pop_front(); check(e.v, e.c, e.req); end
    exec = ex; user = u; flags = f;
    q.push_back(model(ex, u, f));
  endtask

  initial begin
    exec = 1'b1; flags = 8'hFF;
    repeat (3) @(negedge clk);
    check(1'b0, 0, "R1");
    exec = 1'b0; flags = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(1'b0, 0, "R1");
    for (int p = 0; p < 2; p++)
      for (int f = 0; f < 256; f++) step(1'b1, p[0], f[7:0]);
    for (int f = 0; f < 8; f++) step(1'b0, f[0], 8'(f * 37 + 1));
    step(1'b0, 1'b0, 8'h07);
    step(1'b1, 1'b0, 8'h00);
    step(1'b1, 1'b1, 8'h10);
    step(1'b1, 1'b0, 8'h00);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run=%0d expected completion", cyc);
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule